// File: doc/BRIEF.md
# Histogram Display Sweep Controller

This block produces the point stream for an X-Y display of a histogram memory. A channel counter walks the 1024 channels over and over. For each step it issues a read to an external memory that returns data one cycle later. It then presents a horizontal code (the channel index) and an 8-bit vertical code. The vertical code comes either from a linearly scaled count or from a logarithmic code built out of the position of the count's leading one and the bits that follow it. In quadrant mode each memory location of the selected 256-channel segment is read for four consecutive channel indices.

Every 10th or every 50th channel, as selected, is marked. The sweep dwells on a marked channel for a parameterized number of extra steps and raises a marker output, so the scope draws brighter points there. A one-cycle pulse flags the first display of channel 0 in each sweep. The sweep stops stepping and issues no reads while the acquisition side is storing a conversion or while the external clock-inhibit input is high. It then resumes where it stopped, without skipping a channel. Mode inputs are expected to change only while the block is held in reset.

Top module: `disp_sweep`

## Requirements
- R1: While reset is asserted, disp_valid, mark and sweep_rst are 0 and h_code and v_code are 0.
- R2: Each enabled step issues mem_rd with the current channel. Its h_code and v_code appear on the outputs two clock edges later with disp_valid high. Successive distinct h_code values increase by 1, wrapping from 1023 to 0.
- R3: In linear mode (log_mode=0), v_code = min(255, count >> (fs_sel+1)), so fs_sel 0..7 sets full scale from 512 to 65536 counts. Larger counts saturate at 255.
- R4: In log mode (log_mode=1), a count of 0 gives v_code 0x00. A nonzero count whose leading one sits at bit p (p = 15 minus the left shifts that bring it to bit 15) gives v_code[7:4] = p and v_code[3:0] = the four bits just below that leading one. The value 0xFFFF gives 0xFF.
- R5: In log mode, fs_sel has no effect on v_code.
- R6: With quad_en=1, mem_addr = {seg_sel, channel[9:2]}. With quad_en=0, mem_addr = channel.
- R7: While acq_busy is high, mem_rd is 0 and the channel does not advance. disp_valid is 0 two edges after acq_busy is sampled high, and no channel is skipped afterwards.
- R8: While clk_inh is high, the sweep halts exactly as in R7.
- R9: With mark_sel=0 (period 10) or mark_sel=1 (period 50), a channel whose index is a multiple of the period is shown for HOLD_CYC+1 consecutive enabled cycles with mark=1. Every other channel is shown once with mark=0.
- R10: sweep_rst pulses for one cycle on the first display of channel 0 in every sweep. Without pauses, the pulses are 1024 + ceil(1024/period)*HOLD_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_inh | input | 1 | High halts the sweep |
| acq_busy | input | 1 | High while acquisition uses memory |
| log_mode | input | 1 | 1 selects the logarithmic vertical code |
| fs_sel | input | 3 | Linear full-scale select |
| quad_en | input | 1 | Quadrant (256-channel segment) mode |
| seg_sel | input | 2 | Selected segment in quadrant mode |
| mark_sel | input | 1 | 0: mark every 10th channel, 1: every 50th |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory read address |
| mem_data | input | 16 | Read data, valid one cycle after mem_rd |
| h_code | output | 10 | Horizontal code (channel index) |
| v_code | output | 8 | Vertical code |
| disp_valid | output | 1 | h_code/v_code hold a new point |
| mark | output | 1 | Point belongs to an intensified channel |
| sweep_rst | output | 1 | First point of a new sweep |

## Verification
The assertions watch, on every cycle, the relations that hold between ports whatever the data: no output point follows two edges after a paused step, an unmarked channel never appears twice in a row, a sweep_rst only comes with a marked channel 0, and quadrant reads always carry the segment bits. The scaling arithmetic in both vertical modes, the independence of the log code from fs_sel, the exact dwell length on marked channels and the sweep period depend on stored counts and on cycle counting over whole sweeps. Only the bench scenarios can show those, by comparing each point against a model of the memory contents.

// File: rtl/disp_sweep.sv
module disp_sweep #(
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 16,
  parameter int VC_W     = 8,
  parameter int FS_W     = 3,
  parameter int HOLD_CYC = 4,
  parameter int PER_A    = 10,
  parameter int PER_B    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_inh,
  input  logic              acq_busy,
  input  logic              log_mode,
  input  logic [FS_W-1:0]   fs_sel,
  input  logic              quad_en,
  input  logic [1:0]        seg_sel,
  input  logic              mark_sel,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CNT_W-1:0]  mem_data,
  output logic [ADDR_W-1:0] h_code,
  output logic [VC_W-1:0]   v_code,
  output logic              disp_valid,
  output logic              mark,
  output logic              sweep_rst
);
  localparam int CH_W   = $clog2(CNT_W);
  localparam int MANT_W = VC_W - CH_W;
  localparam int PER_MX = (PER_A > PER_B) ? PER_A : PER_B;
  localparam int GRP_W  = $clog2(PER_MX);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1) + 1;
  localparam logic [CH_W-1:0] TOPB = CH_W'(CNT_W - 1);

  logic [ADDR_W-1:0] ch;
  logic [GRP_W-1:0]  grp;
  logic [HOLD_W-1:0] hcnt;
  logic              run, marked, advance;
  logic [GRP_W-1:0]  per_m1;

  logic              rd_q, mk_q, first_q;
  logic [ADDR_W-1:0] ch_q;

  assign run     = !clk_inh && !acq_busy;
  assign marked  = (grp == '0);
  assign advance = run && (!marked || hcnt == HOLD_W'(HOLD_CYC));
  assign per_m1  = mark_sel ? GRP_W'(PER_B - 1) : GRP_W'(PER_A - 1);

  assign mem_rd   = run;
  assign mem_addr = quad_en ? {seg_sel, ch[ADDR_W-1:2]} : ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch   <= '0;
      grp  <= '0;
      hcnt <= '0;
    end else if (advance) begin
      ch   <= ch + 1'b1;
      hcnt <= '0;
      grp  <= (&ch || grp >= per_m1) ? '0 : grp + 1'b1;
    end else if (run) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      mk_q    <= 1'b0;
      first_q <= 1'b0;
      ch_q    <= '0;
    end else begin
      rd_q    <= run;
      mk_q    <= marked;
      first_q <= run && (ch == '0) && (hcnt == '0);
      ch_q    <= ch;
    end
  end

  logic [FS_W:0]     sh_amt;
  logic [CNT_W-1:0]  lin_sh;
  logic [VC_W-1:0]   lin_code;
  logic [CH_W-1:0]   lead;
  logic [CNT_W-1:0]  norm;
  logic [VC_W-1:0]   log_code;

  assign sh_amt   = {1'b0, fs_sel} + 1'b1;
  assign lin_sh   = mem_data >> sh_amt;
  assign lin_code = (|lin_sh[CNT_W-1:VC_W]) ? '1 : lin_sh[VC_W-1:0];

  always_comb begin
    lead = '0;
    for (int i = 0; i < CNT_W; i++)
      if (mem_data[i]) lead = CH_W'(i);
  end

  assign norm     = mem_data << (TOPB - lead);
  assign log_code = (mem_data == '0) ? '0 : {lead, norm[CNT_W-2 -: MANT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      mark       <= 1'b0;
      sweep_rst  <= 1'b0;
      h_code     <= '0;
      v_code     <= '0;
    end else begin
      disp_valid <= rd_q;
      mark       <= rd_q && mk_q;
      sweep_rst  <= rd_q && first_q;
      if (rd_q) begin
        h_code <= ch_q;
        v_code <= log_mode ? log_code : lin_code;
      end
    end
  end
endmodule

module disp_sweep_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_inh,
  input logic              acq_busy,
  input logic              quad_en,
  input logic [1:0]        seg_sel,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] h_code,
  input logic              disp_valid,
  input logic              mark,
  input logic              sweep_rst
);
  assert_busy_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acq_busy, 2) |-> !disp_valid);

  assert_inh_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_inh, 2) |-> !disp_valid);

  assert_quad_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && quad_en) |-> mem_addr[ADDR_W-1 -: 2] == seg_sel);

  assert_single_show_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !mark) |=> !(disp_valid && h_code == $past(h_code)));

  assert_mark_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> disp_valid);

  assert_sweep_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_rst |-> (disp_valid && mark && h_code == '0));
endmodule

bind disp_sweep disp_sweep_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_inh(clk_inh), .acq_busy(acq_busy),
  .quad_en(quad_en), .seg_sel(seg_sel), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .h_code(h_code), .disp_valid(disp_valid), .mark(mark), .sweep_rst(sweep_rst)
);

// File: tb/tb_disp_sweep.sv
module tb_disp_sweep;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0;
  logic clk_inh = 0, acq_busy = 0, log_mode = 0, quad_en = 0, mark_sel = 0;
  logic [2:0] fs_sel = 0;
  logic [1:0] seg_sel = 0;
  logic mem_rd, disp_valid, mark, sweep_rst;
  logic [9:0] mem_addr, h_code;
  logic [15:0] rdata;
  logic [7:0] v_code;
  logic [15:0] mem [1024];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  disp_sweep #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .clk_inh(clk_inh), .acq_busy(acq_busy),
    .log_mode(log_mode), .fs_sel(fs_sel), .quad_en(quad_en), .seg_sel(seg_sel),
    .mark_sel(mark_sel), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(rdata),
    .h_code(h_code), .v_code(v_code), .disp_valid(disp_valid), .mark(mark),
    .sweep_rst(sweep_rst));

  always_ff @(posedge clk) if (mem_rd) rdata <= mem[mem_addr];

  function automatic logic [7:0] lin_exp(logic [15:0] c, int fs);
    int v = int'(c) >> (fs + 1);
    return (v > 255) ? 8'hFF : v[7:0];
  endfunction

  function automatic logic [7:0] log_exp(logic [15:0] c);
    int p = 15;
    logic [31:0] x;
    if (c == 0) return 8'h00;
    while (!c[p]) p--;
    x = {c, 16'h0} >> p;
    return {p[3:0], x[15:12]};
  endfunction

  function automatic int period();
    return mark_sel ? 50 : 10;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(bit lg, int fs, bit q, int seg, bit ms);
    rst_n = 0; clk_inh = 0; acq_busy = 0;
    log_mode = lg; fs_sel = 3'(fs); quad_en = q; seg_sel = 2'(seg); mark_sel = ms;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic observe(int n, string vtag);
    logic [9:0] ph = 0;
    logic [9:0] a;
    logic [7:0] e;
    bit have = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (disp_valid) begin
        a = quad_en ? {seg_sel, h_code[9:2]} : h_code;
        e = log_mode ? log_exp(mem[a]) : lin_exp(mem[a], int'(fs_sel));
        chk(v_code == e, vtag, v_code, e);
        chk(mark == (int'(h_code) % period() == 0), "R9", mark, 0);
        if (have && h_code != ph) chk(h_code == ph + 10'd1, "R2", h_code, ph + 10'd1);
        if (sweep_rst) chk(h_code == 0, "R10", h_code, 0);
        ph = h_code; have = 1;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!disp_valid && !mark && !sweep_rst, "R1", {disp_valid, mark, sweep_rst}, 0);
    chk(h_code == 0 && v_code == 0, "R1", {h_code, v_code}, 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(disp_valid && sweep_rst && h_code == 0, "R2", {disp_valid, sweep_rst, h_code}, 12'h0C00);
  endtask

  task automatic t_linear(int fs);
    restart(0, fs, 0, 0, 0);
    observe(1500, "R3");
  endtask

  task automatic t_log(int fs);
    restart(1, fs, 0, 0, 0);
    observe(1500, fs == 0 ? "R4" : "R5");
  endtask

  task automatic t_quad(int seg);
    restart(0, 2, 1, seg, 0);
    fork
      observe(1500, "R6");
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mem_rd) chk(mem_addr[9:8] == 2'(seg), "R6", mem_addr, seg);
      end
    join
  endtask

  task automatic t_mark(bit ms);
    logic [9:0] ph = 0;
    int run_len = 0, started = 0, expl;
    restart(0, 7, 0, 0, ms);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (disp_valid) begin
        if (run_len > 0 && h_code != ph) begin
          expl = (int'(ph) % period() == 0) ? HOLD + 1 : 1;
          if (started) chk(run_len == expl, "R9", run_len, expl);
          started = 1;
          run_len = 0;
        end
        chk(mark == (int'(h_code) % period() == 0), "R9", mark, 0);
        ph = h_code;
        run_len++;
      end
    end
  endtask

  task automatic t_sweep(bit ms);
    int n = 0, expn;
    restart(0, 0, 0, 0, ms);
    expn = 1024 + ((1023 / period()) + 1) * HOLD;
    do @(negedge clk); while (!sweep_rst);
    do begin @(negedge clk); n++; end while (!sweep_rst && n < 5000);
    chk(n == expn, "R10", n, expn);
  endtask

  task automatic t_pause(bit use_inh);
    string tg = use_inh ? "R8" : "R7";
    restart(0, 1, 0, 0, 0);
    fork
      observe(2500, tg);
      for (int k = 0; k < 8; k++) begin
        repeat (37 + k * 3) @(negedge clk);
        if (use_inh) clk_inh = 1; else acq_busy = 1;
        #1 chk(!mem_rd, tg, mem_rd, 0);
        @(negedge clk);
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          chk(!disp_valid, tg, disp_valid, 0);
        end
        clk_inh = 0; acq_busy = 0;
      end
    join
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      case (i % 8)
        0: mem[i] = 16'h0000;
        1: mem[i] = 16'h0001;
        2: mem[i] = 16'hFFFF;
        3: mem[i] = 16'(i * 64);
        4: mem[i] = 16'h1 << (i % 16);
        5: mem[i] = 16'(i);
        6: mem[i] = 16'(i * i);
        default: mem[i] = 16'h8000 | 16'(i);
      endcase
    end
    t_reset();
    t_linear(0);
    t_linear(3);
    t_linear(7);
    t_log(0);
    t_log(7);
    t_quad(2);
    t_mark(0);
    t_mark(1);
    t_sweep(0);
    t_sweep(1);
    t_pause(0);
    t_pause(1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule